// File: doc/BRIEF.md
# Dual-Field Carry-Save Adder

This block is a purely combinational, word-wide 3-to-2 compressor. It serves both prime-field and binary-field arithmetic. It takes a multiple word `x` together with a redundant value held as a sum word and a carry word, and returns a new sum word, a new carry word and a carry-out. It is meant for the accumulation loop of a word-serial modular multiplier, where redundant form avoids a long carry chain at each step.

A field-select input picks the arithmetic:

- **Prime-field mode** (`field_sel = 1`): each cell is a full adder.
- **Binary-field mode** (`field_sel = 0`): every carry a cell produces is forced to zero. The sum word then becomes the bitwise XOR of the three operands.

Each cell forms `ss XOR sc` once and uses it as a select:

- For the sum, it picks between `x` and `NOT x`.
- For the carry, it picks between two field-gated AND terms.

This keeps the sum and carry paths at the same depth.

The carry word leaves the block shifted up one place. Bit 0 of the output carry word comes from the carry input. The carry from the top cell leaves on its own output. There are no registers and there is no carry-propagate stage. The block has no states: its output is a pure function of its present inputs.

Top module: `dfcsa_top`

## Requirements
- R1: In both modes, sum bit i equals `x[i] ^ ss[i] ^ sc[i]` for every i from 0 to W-1.
- R2: With `field_sel = 1`, output carry bit i+1 (i from 0 to W-2) equals the majority of `x[i]`, `ss[i]` and `sc[i]`.
- R3: With `field_sel = 0`, output carry bits W-1 down to 1 and the carry-out are all 0.
- R4: Output carry bit 0 equals the carry input in both modes.
- R5: With `field_sel = 1`, the carry-out equals the majority of `x[W-1]`, `ss[W-1]` and `sc[W-1]`.
- R6: With `field_sel = 1`, `x + ss + sc + cin` equals `sum + carry + cout * 2^W` as unsigned integers.
- R7: The width W is a parameter (default 32), and the behaviour above holds for any W of 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | W | Multiple word to be added |
| ss_in | input | W | Incoming sum word |
| sc_in | input | W | Incoming carry word |
| cin | input | 1 | Carry placed at bit 0 of the outgoing carry word |
| field_sel | input | 1 | 1 selects prime-field mode, 0 selects binary-field mode |
| sum_o | output | W | Outgoing sum word |
| carry_o | output | W | Outgoing carry word, shifted up by one place |
| cout_o | output | 1 | Carry produced by the top cell |

## Verification
The in-line assertions assume that every input bit is 0 or 1. They skip any evaluation in which an input is unknown, so a check never fires on values that have not yet been driven. The bench drives every input of both instances from the first cycle and never leaves a bit floating. It covers both values of `field_sel` in every pattern set: exhaustively for a four-bit instance, and with directed extremes plus random words for the 32-bit default.

// File: rtl/dfcsa_pkg.sv
package dfcsa_pkg;

    typedef enum logic {
        FIELD_BINARY = 1'b0,
        FIELD_PRIME  = 1'b1
    } field_e;

endpackage

// File: rtl/dfcsa_cell.sv
module dfcsa_cell
    import dfcsa_pkg::*;
(
    input  logic x_b,
    input  logic ss_b,
    input  logic sc_b,
    input  logic field_sel,
    output logic sum_b,
    output logic cy_b
);

    logic half_x;
    logic gate_x;
    logic gate_sc;

    // shared select: ss and sc differ
    assign half_x  = ss_b ^ sc_b;
    assign gate_x  = x_b  & field_sel;
    assign gate_sc = sc_b & field_sel;

    always_comb begin
        sum_b = half_x ? ~x_b   : x_b;
        cy_b  = half_x ? gate_x : gate_sc;
    end

endmodule

// File: rtl/dfcsa_array.sv
module dfcsa_array
    import dfcsa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] x_w,
    input  logic [W-1:0] ss_w,
    input  logic [W-1:0] sc_w,
    input  logic         field_sel,
    output logic [W-1:0] sum_w,
    output logic [W-1:0] cy_w
);

    for (genvar g = 0; g < W; g++) begin : g_cell
        dfcsa_cell u_cell (
            .x_b       (x_w[g]),
            .ss_b      (ss_w[g]),
            .sc_b      (sc_w[g]),
            .field_sel (field_sel),
            .sum_b     (sum_w[g]),
            .cy_b      (cy_w[g])
        );
    end

    // R1 and R2 at cell level
    always_comb begin
        if (!$isunknown({x_w, ss_w, sc_w, field_sel})) begin
            for (int i = 0; i < W; i++) begin
                // R1
                cell_sum_chk: assert (sum_w[i] == (x_w[i] ^ ss_w[i] ^ sc_w[i]))
                    else $error("cell sum mismatch at bit %0d", i);
                // R2
                cell_major_chk: assert (cy_w[i] == (field_sel &
                        ((x_w[i] & ss_w[i]) | (x_w[i] & sc_w[i]) | (ss_w[i] & sc_w[i]))))
                    else $error("cell carry mismatch at bit %0d", i);
            end
        end
    end

endmodule

// File: rtl/dfcsa_top.sv
module dfcsa_top
    import dfcsa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] ss_in,
    input  logic [W-1:0] sc_in,
    input  logic         cin,
    input  logic         field_sel,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o,
    output logic         cout_o
);

    localparam int EW = W + 2;

    logic [W-1:0] cy_raw;
    field_e       mode;

    assign mode = field_e'(field_sel);

    dfcsa_array #(.W(W)) u_array (
        .x_w       (x_in),
        .ss_w      (ss_in),
        .sc_w      (sc_in),
        .field_sel (field_sel),
        .sum_w     (sum_o),
        .cy_w      (cy_raw)
    );

    // R4: carry word shifted up, carry input fills bit 0
    assign carry_o = {cy_raw[W-2:0], cin};
    assign cout_o  = cy_raw[W-1];

    logic [EW-1:0] lhs_total;
    logic [EW-1:0] rhs_total;

    always_comb begin
        lhs_total = EW'(x_in) + EW'(ss_in) + EW'(sc_in) + EW'(cin);
        rhs_total = EW'(sum_o) + EW'(carry_o) + (EW'(cout_o) << W);
    end

    always_comb begin
        if (!$isunknown({x_in, ss_in, sc_in, cin, field_sel})) begin
            // R6
            prime_total_chk: assert (mode != FIELD_PRIME || lhs_total == rhs_total)
                else $error("prime-mode total mismatch");
            // R3
            binary_nocarry_chk: assert (mode != FIELD_BINARY ||
                    (carry_o[W-1:1] == '0 && cout_o == 1'b0))
                else $error("binary-mode carry not zero");
            // R1
            binary_xor_chk: assert (mode != FIELD_BINARY || sum_o == (x_in ^ ss_in ^ sc_in))
                else $error("binary-mode sum not xor");
            // R5
            top_cout_chk: assert (cout_o == (field_sel &
                    ((x_in[W-1] & ss_in[W-1]) | (x_in[W-1] & sc_in[W-1]) | (ss_in[W-1] & sc_in[W-1]))))
                else $error("carry-out mismatch");
        end
    end

endmodule

// File: tb/dfcsa_top_tb_top.sv
module dfcsa_top_tb_top;

    localparam int WS = 4;
    localparam int WB = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [WS-1:0] xs, sss, scs, sum_s, car_s;
    logic          cin_s, fs_s, cout_s;
    logic [WB-1:0] xb, ssb, scb, sum_b, car_b;
    logic          cin_b, fs_b, cout_b;

    dfcsa_top #(.W(WS)) small_i (
        .x_in(xs), .ss_in(sss), .sc_in(scs), .cin(cin_s), .field_sel(fs_s),
        .sum_o(sum_s), .carry_o(car_s), .cout_o(cout_s));

    dfcsa_top #(.W(WB)) dut_i (
        .x_in(xb), .ss_in(ssb), .sc_in(scb), .cin(cin_b), .field_sel(fs_b),
        .sum_o(sum_b), .carry_o(car_b), .cout_o(cout_b));

    typedef struct packed {
        logic [WS-1:0] xs, ss, sc;
        logic          cin_s, fs_s;
        logic [WS-1:0] e_sum_s, e_car_s;
        logic          e_cout_s;
        logic [WB-1:0] xb, sb, cb;
        logic          cin_b, fs_b;
        logic [WB-1:0] e_sum_b, e_car_b;
        logic          e_cout_b;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    function automatic logic maj(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: apply one vector pair and push expectations
    task automatic drive(logic [WS-1:0] a, logic [WS-1:0] s, logic [WS-1:0] c, logic ci, logic f,
                         logic [WB-1:0] A, logic [WB-1:0] S, logic [WB-1:0] C, logic CI, logic F);
        item_t it;
        @(negedge clk);
        it = '0;
        it.xs = a; it.ss = s; it.sc = c; it.cin_s = ci; it.fs_s = f;
        it.xb = A; it.sb = S; it.cb = C; it.cin_b = CI; it.fs_b = F;
        it.e_sum_s = a ^ s ^ c;
        it.e_car_s[0] = ci;
        for (int i = 0; i < WS - 1; i++) it.e_car_s[i+1] = f & maj(a[i], s[i], c[i]);
        it.e_cout_s = f & maj(a[WS-1], s[WS-1], c[WS-1]);
        it.e_sum_b = A ^ S ^ C;
        it.e_car_b[0] = CI;
        for (int i = 0; i < WB - 1; i++) it.e_car_b[i+1] = F & maj(A[i], S[i], C[i]);
        it.e_cout_b = F & maj(A[WB-1], S[WB-1], C[WB-1]);
        xs = a; sss = s; scs = c; cin_s = ci; fs_s = f;
        xb = A; ssb = S; scb = C; cin_b = CI; fs_b = F;
        sb_q.push_back(it);
    endtask

    // monitor: compare at the next rising edge
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            logic [WS+1:0] ls, rs;
            logic [WB+1:0] lb, rb;
            it = sb_q.pop_front();
            chk("R1 small sum", 64'(sum_s), 64'(it.e_sum_s));
            chk(it.fs_s ? "R2 small carry" : "R3 small carry", 64'(car_s[WS-1:1]), 64'(it.e_car_s[WS-1:1]));
            chk("R4 small cin", 64'(car_s[0]), 64'(it.cin_s));
            chk(it.fs_s ? "R5 small cout" : "R3 small cout", 64'(cout_s), 64'(it.e_cout_s));
            chk("R1 R7 big sum", 64'(sum_b), 64'(it.e_sum_b));
            chk(it.fs_b ? "R2 R7 big carry" : "R3 R7 big carry", 64'(car_b), 64'(it.e_car_b));
            chk(it.fs_b ? "R5 big cout" : "R3 big cout", 64'(cout_b), 64'(it.e_cout_b));
            if (it.fs_s) begin
                ls = (WS+2)'(it.xs) + (WS+2)'(it.ss) + (WS+2)'(it.sc) + (WS+2)'(it.cin_s);
                rs = (WS+2)'(sum_s) + (WS+2)'(car_s) + ((WS+2)'(cout_s) << WS);
                chk("R6 small total", 64'(rs), 64'(ls));
            end
            if (it.fs_b) begin
                lb = (WB+2)'(it.xb) + (WB+2)'(it.sb) + (WB+2)'(it.cb) + (WB+2)'(it.cin_b);
                rb = (WB+2)'(sum_b) + (WB+2)'(car_b) + ((WB+2)'(cout_b) << WB);
                chk("R6 big total", 64'(rb), 64'(lb));
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        xs = '0; sss = '0; scs = '0; cin_s = 0; fs_s = 0;
        xb = '0; ssb = '0; scb = '0; cin_b = 0; fs_b = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero inputs give zero outputs
        chk("R1 reset sum", 64'(sum_b), 64'd0);
        chk("R3 reset carry", 64'({car_b, cout_b}), 64'd0);
        rst = 1'b0;
        // directed extremes, both modes
        for (int f = 0; f < 2; f++) begin
            drive('1, '1, '1, 1'b1, f[0], '1, '1, '1, 1'b1, f[0]);
            drive('0, '0, '0, 1'b1, f[0], '0, '0, '0, 1'b1, f[0]);
            drive('1, '0, '0, 1'b0, f[0], '1, '0, '1, 1'b0, f[0]);
            drive(4'hA, 4'h5, 4'hF, 1'b0, f[0], 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 1'b1, f[0]);
        end
        // exhaustive small, random big
        for (int v = 0; v < 16384; v++) begin
            logic [13:0] u;
            u = 14'(v);
            drive(u[11:8], u[7:4], u[3:0], u[12], u[13],
                  $urandom, $urandom, $urandom, 1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule